// File: doc/BRIEF.md
# Element-Width Overridable Byte-Lane Register File

This block is a register file of 128 registers, 64 bits each, organised internally as a store of 1024 bytes. It has one write port and two read ports. Every port gives a base register, a 2-bit element width code, an element offset and a vector flag. The port then reads or writes one typed element. Elements of 8, 16, 32 or 64 bits at consecutive offsets sit next to each other starting at the base register, and they run on into the registers that follow. The file therefore acts as a set of overlapping typed arrays, with one array starting at every register.

A write changes only the bytes of the element it addresses. Every byte lane has its own write enable, so a narrow write never clears or changes the other bytes of the register. Elements are always naturally aligned, so an element never crosses a register boundary. Each read port delivers its element zero-extended to 64 bits, one clock after the request.

Top module: `elw_regfile`

## Requirements
- R1: While `rst` is high, both read data outputs are 0.
- R2: The width code selects the element size: 00 is 64 bits, 01 is 32 bits, 10 is 16 bits and 11 is 8 bits. An element of byte size n at offset k from base register b starts at byte address b*8 + k*n. It lies in register (address / 8), and its least significant byte is in byte lane (address mod 8), bits 8*lane+7 down to 8*lane. Higher bytes of the element take the next lanes upward.
- R3: When the vector flag of a port is 0, that port uses offset 0 and ignores its offset input.
- R4: A write changes only the bytes of its own element. All other bytes of the file keep their previous contents.
- R5: Three 16-bit writes at offsets 0, 1 and 2 of one register leave bits 63:48 of that register unchanged.
- R6: Seven 8-bit writes at offsets 0 to 6 leave byte 7 of the register unchanged. A 64-bit write replaces all eight bytes.
- R7: Read data is the element value, zero-extended to 64 bits.
- R8: Read data appears one clock after the read request. It shows the contents as they were before that clock edge, so a write at the same edge is not visible to the read.
- R9: Byte addresses wrap modulo 1024. For example, offset 9 of an 8-bit vector based at register 127 lands in byte lane 1 of register 0.
- R10: The two read ports work independently of each other and of the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_base | input | 7 | Write base register |
| wr_width | input | 2 | Write element width code |
| wr_off | input | 10 | Write element offset |
| wr_vec | input | 1 | Write operand is a vector |
| wr_data | input | 64 | Write element value, in the low bits |
| ra_base | input | 7 | Read port A base register |
| ra_width | input | 2 | Read port A width code |
| ra_off | input | 10 | Read port A element offset |
| ra_vec | input | 1 | Read port A operand is a vector |
| ra_data | output | 64 | Read port A element, zero-extended |
| rb_base | input | 7 | Read port B base register |
| rb_width | input | 2 | Read port B width code |
| rb_off | input | 10 | Read port B element offset |
| rb_vec | input | 1 | Read port B operand is a vector |
| rb_data | output | 64 | Read port B element, zero-extended |

## Verification
The assertions assume that every input holds a known value once reset is released. They also assume that `wr_en` is never unknown, because the checks on the byte mask and on lane alignment depend on it. The bench meets these assumptions by driving every input to a defined value from time zero and by limiting random values to the width of each port. It also writes every register with a full-width value before it compares any read, so no check depends on the uninitialised contents of the store.

// File: rtl/elw_pkg.sv
package elw_pkg;
  // Width codes: 00 = 64 bit, 01 = 32 bit, 10 = 16 bit, 11 = 8 bit.
  localparam logic [1:0] EW64 = 2'b00;
  localparam logic [1:0] EW32 = 2'b01;
  localparam logic [1:0] EW16 = 2'b10;
  localparam logic [1:0] EW8  = 2'b11;

  // Number of bytes in one element of the given width code.
  function automatic int unsigned ew_bytes(input logic [1:0] code);
    case (code)
      EW64:    ew_bytes = 8;
      EW32:    ew_bytes = 4;
      EW16:    ew_bytes = 2;
      default: ew_bytes = 1;
    endcase
  endfunction
endpackage

// File: rtl/elw_addr.sv
module elw_addr
  import elw_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int BPR   = 8,
  parameter int OFF_W = 10
) (
  input  logic [$clog2(NREGS)-1:0] base,
  input  logic [1:0]               width,
  input  logic [OFF_W-1:0]         off,
  input  logic                     vec,
  output logic [$clog2(NREGS)-1:0] reg_idx,
  output logic [$clog2(BPR)-1:0]   lane,
  output logic [BPR-1:0]           be
);
  localparam int REG_W  = $clog2(NREGS);
  localparam int LANE_W = $clog2(BPR);
  localparam int ADDR_W = REG_W + LANE_W;

  logic [OFF_W-1:0]  eff_off;
  logic [1:0]        sh;
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] byte_addr;
  logic [BPR-1:0]    base_mask;

  // A scalar operand always uses element 0.
  assign eff_off   = vec ? off : '0;
  assign sh        = 2'd3 - width;
  assign scaled    = ADDR_W'(eff_off) << sh;
  assign byte_addr = {base, LANE_W'(0)} + scaled;  // wraps modulo store size
  assign reg_idx   = byte_addr[ADDR_W-1:LANE_W];
  assign lane      = byte_addr[LANE_W-1:0];

  always_comb begin
    for (int i = 0; i < BPR; i++) begin
      base_mask[i] = (i < int'(ew_bytes(width)));
    end
  end

  assign be = base_mask << lane;
endmodule

// File: rtl/elw_bank.sv
module elw_bank #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [7:0]               rdata_a,
  output logic [7:0]               rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered reads return the contents from before the edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
    end
  end
endmodule

// File: rtl/elw_rdalign.sv
module elw_rdalign
  import elw_pkg::*;
#(
  parameter int BPR = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(BPR)-1:0] lane,
  input  logic [1:0]             width,
  input  logic [BPR*8-1:0]       word_q,
  output logic [BPR*8-1:0]       data
);
  localparam int LANE_W = $clog2(BPR);

  logic [LANE_W-1:0] lane_q;
  logic [1:0]        width_q;
  logic [BPR*8-1:0]  keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q  <= '0;
      width_q <= EW64;
    end else begin
      lane_q  <= lane;
      width_q <= width;
    end
  end

  always_comb begin
    for (int i = 0; i < BPR; i++) begin
      keep[i*8 +: 8] = (i < int'(ew_bytes(width_q))) ? 8'hFF : 8'h00;
    end
  end

  assign data = (word_q >> {lane_q, 3'b000}) & keep;

  // R7: nothing above the element width is ever set
  a_r7_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (data >> ((BPR >> width_q) * 8)) == '0);
endmodule

// File: rtl/elw_regfile.sv
module elw_regfile
  import elw_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  parameter int OFF_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_base,
  input  logic [1:0]               wr_width,
  input  logic [OFF_W-1:0]         wr_off,
  input  logic                     wr_vec,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [$clog2(NREGS)-1:0] ra_base,
  input  logic [1:0]               ra_width,
  input  logic [OFF_W-1:0]         ra_off,
  input  logic                     ra_vec,
  output logic [XLEN-1:0]          ra_data,
  input  logic [$clog2(NREGS)-1:0] rb_base,
  input  logic [1:0]               rb_width,
  input  logic [OFF_W-1:0]         rb_off,
  input  logic                     rb_vec,
  output logic [XLEN-1:0]          rb_data
);
  localparam int BPR    = XLEN / 8;
  localparam int REG_W  = $clog2(NREGS);
  localparam int LANE_W = $clog2(BPR);
  localparam int NRD    = 2;

  // Write port addressing
  logic [REG_W-1:0]  w_reg;
  logic [LANE_W-1:0] w_lane;
  logic [BPR-1:0]    w_be;
  logic [XLEN-1:0]   w_shift;

  elw_addr #(.NREGS(NREGS), .BPR(BPR), .OFF_W(OFF_W)) u_waddr (
    .base(wr_base), .width(wr_width), .off(wr_off), .vec(wr_vec),
    .reg_idx(w_reg), .lane(w_lane), .be(w_be)
  );

  assign w_shift = wr_data << {w_lane, 3'b000};

  // Read port addressing and alignment
  logic [REG_W-1:0]  r_base  [NRD];
  logic [1:0]        r_width [NRD];
  logic [OFF_W-1:0]  r_off   [NRD];
  logic              r_vec   [NRD];
  logic [REG_W-1:0]  r_reg   [NRD];
  logic [LANE_W-1:0] r_lane  [NRD];
  logic [BPR-1:0]    r_be    [NRD];
  logic [XLEN-1:0]   r_word  [NRD];
  logic [XLEN-1:0]   r_data  [NRD];

  assign r_base[0] = ra_base;  assign r_width[0] = ra_width;
  assign r_off[0]  = ra_off;   assign r_vec[0]   = ra_vec;
  assign r_base[1] = rb_base;  assign r_width[1] = rb_width;
  assign r_off[1]  = rb_off;   assign r_vec[1]   = rb_vec;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    elw_addr #(.NREGS(NREGS), .BPR(BPR), .OFF_W(OFF_W)) u_raddr (
      .base(r_base[p]), .width(r_width[p]), .off(r_off[p]), .vec(r_vec[p]),
      .reg_idx(r_reg[p]), .lane(r_lane[p]), .be(r_be[p])
    );
    elw_rdalign #(.BPR(BPR)) u_align (
      .clk(clk), .rst(rst), .lane(r_lane[p]), .width(r_width[p]),
      .word_q(r_word[p]), .data(r_data[p])
    );
  end

  // One byte-wide bank per lane, each with its own write enable.
  for (genvar l = 0; l < BPR; l++) begin : g_bank
    elw_bank #(.DEPTH(NREGS)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_en & w_be[l]),
      .waddr(w_reg),
      .wdata(w_shift[l*8 +: 8]),
      .raddr_a(r_reg[0]),
      .raddr_b(r_reg[1]),
      .rdata_a(r_word[0][l*8 +: 8]),
      .rdata_b(r_word[1][l*8 +: 8])
    );
  end

  assign ra_data = r_data[0];
  assign rb_data = r_data[1];

  // R3: a scalar write lands in lane 0 of its base register
  a_r3_scalar_base: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_vec) |-> (w_lane == '0 && w_reg == wr_base));

  // R4: the number of enabled byte lanes equals the element size
  a_r4_be_count: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(w_be) == (BPR >> wr_width)));

  // R2: elements are naturally aligned inside a register
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((int'(w_lane) % (BPR >> wr_width)) == 0));

  // R2: the lowest enabled lane is the element's start lane
  a_r2_start_lane: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> w_be[w_lane]);
endmodule

// File: tb/elw_regfile_bench.sv
module elw_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0;
  logic [6:0]  wr_base = '0, ra_base = '0, rb_base = '0;
  logic [1:0]  wr_width = '0, ra_width = '0, rb_width = '0;
  logic [9:0]  wr_off = '0, ra_off = '0, rb_off = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] ra_data, rb_data;

  int total = 0;
  int bad = 0;
  logic [7:0] bm [1024];

  always #5 clk = ~clk;

  elw_regfile u_elw_regfile (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_base(wr_base), .wr_width(wr_width), .wr_off(wr_off),
    .wr_vec(wr_vec), .wr_data(wr_data),
    .ra_base(ra_base), .ra_width(ra_width), .ra_off(ra_off), .ra_vec(ra_vec),
    .ra_data(ra_data),
    .rb_base(rb_base), .rb_width(rb_width), .rb_off(rb_off), .rb_vec(rb_vec),
    .rb_data(rb_data)
  );

  function automatic int nb(input logic [1:0] w);
    return 8 >> w;
  endfunction

  function automatic int baddr(input logic [6:0] b, input logic [1:0] w,
                               input logic [9:0] k, input logic v);
    int kk = v ? int'(k) : 0;
    return (int'(b) * 8 + kk * nb(w)) % 1024;
  endfunction

  function automatic logic [63:0] mread(input logic [6:0] b, input logic [1:0] w,
                                        input logic [9:0] k, input logic v);
    logic [63:0] r = '0;
    int a = baddr(b, w, k, v);
    for (int i = 0; i < nb(w); i++) r[i*8 +: 8] = bm[(a + i) % 1024];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: expectations come from the model before this edge's write.
  task automatic step(input string tag, input bit chk);
    logic [63:0] ea = mread(ra_base, ra_width, ra_off, ra_vec);
    logic [63:0] eb = mread(rb_base, rb_width, rb_off, rb_vec);
    if (wr_en) begin
      int a = baddr(wr_base, wr_width, wr_off, wr_vec);
      for (int i = 0; i < nb(wr_width); i++) bm[(a + i) % 1024] = wr_data[i*8 +: 8];
    end
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      check({tag, " port A"}, ra_data, ea);
      check({tag, " port B"}, rb_data, eb);
    end
  endtask

  task automatic setw(input logic en, input logic [6:0] b, input logic [1:0] w,
                      input logic [9:0] k, input logic v, input logic [63:0] d);
    wr_en = en; wr_base = b; wr_width = w; wr_off = k; wr_vec = v; wr_data = d;
  endtask

  task automatic seta(input logic [6:0] b, input logic [1:0] w,
                      input logic [9:0] k, input logic v);
    ra_base = b; ra_width = w; ra_off = k; ra_vec = v;
  endtask

  task automatic setb(input logic [6:0] b, input logic [1:0] w,
                      input logic [9:0] k, input logic v);
    rb_base = b; rb_width = w; rb_off = k; rb_vec = v;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    seta(7'd3, 2'b00, '0, 1'b0);
    setb(7'd9, 2'b11, '0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset port A", ra_data, 64'h0);
    check("R1 reset port B", rb_data, 64'h0);
    rst = 1'b0;

    // Fill every register with a full-width value.
    for (int r = 0; r < 128; r++) begin
      setw(1'b1, 7'(r), 2'b00, '0, 1'b0, {$urandom, $urandom});
      step("init", 1'b0);
    end

    // R5: three 16-bit writes leave bits 63:48 alone
    setw(1'b1, 7'd10, 2'b00, '0, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD);
    step("R5 setup", 1'b0);
    for (int k = 0; k < 3; k++) begin
      setw(1'b1, 7'd10, 2'b10, 10'(k), 1'b1, 64'(16'h1110 + k));
      step("R5 write", 1'b0);
    end
    wr_en = 1'b0;
    seta(7'd10, 2'b00, '0, 1'b0);
    setb(7'd10, 2'b10, 10'd3, 1'b1);
    step("R5 upper bits kept", 1'b1);
    check("R5 literal", ra_data, 64'hAAAA_1112_1111_1110);

    // R6: seven byte writes keep byte 7; a full write replaces all
    setw(1'b1, 7'd20, 2'b00, '0, 1'b0, 64'h7766_5544_3322_1100);
    step("R6 setup", 1'b0);
    for (int k = 0; k < 7; k++) begin
      setw(1'b1, 7'd20, 2'b11, 10'(k), 1'b1, 64'(8'hE0 + k));
      step("R6 write", 1'b0);
    end
    wr_en = 1'b0;
    seta(7'd20, 2'b00, '0, 1'b0);
    setb(7'd20, 2'b11, 10'd7, 1'b1);
    step("R6 byte 7 kept", 1'b1);
    check("R6 literal", ra_data, 64'h77E6_E5E4_E3E2_E1E0);
    setw(1'b1, 7'd20, 2'b00, '0, 1'b0, 64'h0123_4567_89AB_CDEF);
    step("R6 full write", 1'b0);
    wr_en = 1'b0;
    step("R6 full replaced", 1'b1);
    check("R6 full literal", ra_data, 64'h0123_4567_89AB_CDEF);

    // R3: scalar write ignores its offset
    setw(1'b1, 7'd30, 2'b11, 10'd5, 1'b0, 64'h5A);
    step("R3 write", 1'b0);
    wr_en = 1'b0;
    seta(7'd30, 2'b11, '0, 1'b1);
    setb(7'd30, 2'b11, 10'd77, 1'b0);
    step("R3 scalar offset ignored", 1'b1);
    check("R3 literal", rb_data, 64'h5A);

    // R9: wrap to register 0 lane 1
    setw(1'b1, 7'd127, 2'b11, 10'd9, 1'b1, 64'hC3);
    step("R9 write", 1'b0);
    wr_en = 1'b0;
    seta(7'd0, 2'b11, 10'd1, 1'b1);
    setb(7'd127, 2'b11, 10'd9, 1'b1);
    step("R9 wrap", 1'b1);
    check("R9 literal", ra_data, 64'hC3);

    // R2: a 16-bit vector spills into the next register, lanes 5:4
    setw(1'b1, 7'd5, 2'b10, 10'd6, 1'b1, 64'hBEEF);
    step("R2 write", 1'b0);
    wr_en = 1'b0;
    seta(7'd6, 2'b00, '0, 1'b0);
    setb(7'd6, 2'b10, 10'd2, 1'b1);
    step("R2 spill", 1'b1);
    check("R2 lanes", (ra_data >> 32) & 64'hFFFF, 64'hBEEF);
    check("R7 zero ext", rb_data, 64'hBEEF);

    // R8: same-edge write is not visible to the read
    setw(1'b1, 7'd40, 2'b00, '0, 1'b0, 64'hFEED_FACE_CAFE_F00D);
    seta(7'd40, 2'b00, '0, 1'b0);
    setb(7'd40, 2'b01, 10'd1, 1'b1);
    step("R8 old data", 1'b1);
    wr_en = 1'b0;
    step("R8 new data", 1'b1);
    check("R8 literal", ra_data, 64'hFEED_FACE_CAFE_F00D);

    // Random mix for R2, R4, R7, R10
    for (int n = 0; n < 3000; n++) begin
      setw(1'($urandom), 7'($urandom), 2'($urandom), 10'($urandom), 1'($urandom),
           {$urandom, $urandom});
      seta(7'($urandom), 2'($urandom), 10'($urandom), 1'($urandom));
      setb(7'($urandom), 2'($urandom), 10'($urandom), 1'($urandom));
      step("R4 R7 R10 random", 1'b1);
    end
    finish_run();
  end
endmodule